// File: doc/BRIEF.md
# PLL Divider Setting Calculator

This block turns a requested output frequency and a reference frequency into the settings a fractional-N PLL needs. The first setting is a fixed-point feedback divider word, with an integer/fraction split that can be configured. The second is a power-of-two post-divider, given as an exponent. The block then reports the output frequency that this pair of settings actually produces. It can also skip the search and work in reverse: from a divider word and post-divider exponent supplied by the caller, it computes only the achieved rate.

A request is latched on `start`, when the block is idle or showing a result. A controller moves through named states:

- ST_IDLE waits for the first request.
- ST_PREP clamps the target, picks the post-divider and forms the dividend.
- ST_DIVIDE runs a restoring divider, one quotient bit per cycle.
- ST_RATE evaluates the achieved frequency.
- ST_DONE holds the results with `valid` high.
- ST_FAULT holds `err` high when the reference is zero.

The transitions are:

- From ST_IDLE, ST_DONE or ST_FAULT, `start` moves to ST_PREP.
- From ST_PREP, a zero reference moves to ST_FAULT. A reverse request moves to ST_RATE. Any other request moves to ST_DIVIDE.
- From ST_DIVIDE, the divider's done pulse moves to ST_RATE.
- ST_RATE always moves to ST_DONE.

Top module: `pll_ratio_calc`

## Requirements
- R1: On a forward request, a target above `vco_max_hz` is replaced by `vco_max_hz` before any other step.
- R2: With `table_en` low, the post-divider exponent k is the smallest of 0,1,2,3,4 for which target·2^k is at least the minimum VCO frequency. It is 4 when no exponent qualifies. `pdlog_o` carries k, so the ratio is 2^k.
- R3: A `vco_min_hz` of zero stands for 1,000,000,000 Hz. Any other value is used as given.
- R4: An `int_bits` of zero stands for 7. `word_bits` above 32 counts as 32. The fraction bit count F is word_bits − int_bits when that is positive, and 0 otherwise.
- R5: In forward mode, `word_o` is the low 32 bits of floor((target << (k+F)) / ref_hz).
- R6: `rate_o` is ceil(ceil(ref_hz·word / 2^F) / 2^k), with word and k being the values shown on `word_o` and `pdlog_o`.
- R7: With `table_en` high, entry i occupies `table_hz[32i+31:32i]`. The target is first limited to entry 0. k then starts at 0 and advances while entry k+1 exists, is nonzero, and the target is not above it.
- R8: With `rev_mode` high, no search is made. `word_o` equals `word_in`, `pdlog_o` equals `pdlog_in`, and `rate_o` follows R6.
- R9: A request with `ref_hz` zero raises `err` and keeps `valid` low. The flag stays high until the next accepted `start`.
- R10: Once `valid` rises, it and all results stay unchanged until the next `start`. A `start` is accepted only when the block is idle, done or faulted. A `start` given while a request is in progress is ignored.
- R11: During and after reset, `valid`, `err`, `word_o`, `pdlog_o` and `rate_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; all request inputs are latched with it |
| rev_mode | input | 1 | 1: rate-only evaluation of `word_in`/`pdlog_in` |
| target_hz | input | 32 | Requested output frequency |
| ref_hz | input | 32 | Reference frequency |
| vco_max_hz | input | 32 | Upper frequency limit |
| vco_min_hz | input | 32 | Minimum VCO frequency, 0 = default |
| word_bits | input | 6 | Total divider word width |
| int_bits | input | 6 | Integer bits of the word, 0 = default |
| table_en | input | 1 | Use the threshold table for the post-divider |
| table_hz | input | 160 | Five 32-bit thresholds, entry 0 lowest |
| word_in | input | 32 | Divider word for reverse mode |
| pdlog_in | input | 3 | Post-divider exponent for reverse mode |
| word_o | output | 32 | Divider word |
| pdlog_o | output | 3 | Post-divider exponent |
| rate_o | output | 64 | Achieved output frequency |
| valid | output | 1 | Results stable |
| err | output | 1 | Zero reference seen |

## Verification
Result presentation and request acceptance can coincide. In the same cycle that `valid` first reads high, the bench raises `start` for the next request. The scoreboard must then see the old result once and the new result later, with `valid` dropping in between. A second overlap is a `start` with different inputs arriving in the middle of a division. It is judged by the scoreboard receiving no extra result and by the values of the original request arriving intact.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIVIDE,
        ST_RATE,
        ST_DONE,
        ST_FAULT
    } pllc_state_e;
endpackage

// File: rtl/pllc_postdiv_sel.sv
module pllc_postdiv_sel #(
    parameter int FREQ_W = 32,
    parameter int TBL_N  = 5,
    parameter int LOG_W  = 3,
    parameter int SRCH_N = 5
) (
    input  logic [FREQ_W-1:0]       target,
    input  logic [FREQ_W-1:0]       vmax,
    input  logic [FREQ_W-1:0]       vmin_eff,
    input  logic                    tbl_en,
    input  logic [TBL_N*FREQ_W-1:0] tbl,
    output logic [FREQ_W-1:0]       target_eff,
    output logic [LOG_W-1:0]        pdlog
);
    localparam int EXT_W = FREQ_W + SRCH_N;

    logic [FREQ_W-1:0] lim;
    logic [FREQ_W-1:0] entry0;
    logic [EXT_W-1:0]  scaled;
    logic              stop;

    assign entry0 = tbl[FREQ_W-1:0];

    always_comb begin
        lim    = (target > vmax) ? vmax : target;
        pdlog  = '0;
        stop   = 1'b0;
        scaled = '0;
        if (tbl_en) begin
            if (lim > entry0) lim = entry0;
            for (int i = 1; i < TBL_N; i++) begin
                if (!stop) begin
                    if (tbl[i*FREQ_W +: FREQ_W] != '0 &&
                        !(lim > tbl[i*FREQ_W +: FREQ_W]))
                        pdlog = LOG_W'(i);
                    else
                        stop = 1'b1;
                end
            end
        end else begin
            pdlog = LOG_W'(SRCH_N - 1);
            for (int i = 0; i < SRCH_N; i++) begin
                scaled = EXT_W'(lim) << i;
                if (!stop && scaled >= EXT_W'(vmin_eff)) begin
                    pdlog = LOG_W'(i);
                    stop  = 1'b1;
                end
            end
        end
        target_eff = lim;
    end
endmodule

// File: rtl/pllc_restoring_div.sv
module pllc_restoring_div #(
    parameter int NUM_W = 71,
    parameter int DEN_W = 32,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic [OUT_W-1:0] quotient,
    output logic             done
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W+1:0] trial;

    assign shifted  = {rem_q, quo_q[NUM_W-1]};
    assign trial    = {1'b0, shifted} - {2'b00, den_q};
    assign quotient = quo_q[OUT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                quo_q <= dividend;
                rem_q <= '0;
                den_q <= divisor;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[DEN_W+1]) begin
                    rem_q <= trial[DEN_W-1:0];
                    quo_q <= {quo_q[NUM_W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[DEN_W-1:0];
                    quo_q <= {quo_q[NUM_W-2:0], 1'b0};
                end
                if (cnt_q == CNT_W'(NUM_W - 1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < den_q)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
endmodule

// File: rtl/pllc_rate_eval.sv
module pllc_rate_eval #(
    parameter int FREQ_W = 32,
    parameter int WORD_W = 32,
    parameter int LOG_W  = 3,
    parameter int SH_W   = 6
) (
    input  logic [FREQ_W-1:0]        ref_hz,
    input  logic [WORD_W-1:0]        word,
    input  logic [SH_W-1:0]          frac,
    input  logic [LOG_W-1:0]         pdlog,
    output logic [FREQ_W+WORD_W-1:0] rate
);
    localparam int PROD_W = FREQ_W + WORD_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] fmask;
    logic [PROD_W-1:0] vco;
    logic [PROD_W-1:0] pmask;

    always_comb begin
        prod  = PROD_W'(ref_hz) * PROD_W'(word);
        fmask = (PROD_W'(1) << frac) - PROD_W'(1);
        vco   = (prod >> frac) + PROD_W'(|(prod & fmask));
        pmask = (PROD_W'(1) << pdlog) - PROD_W'(1);
        rate  = (vco >> pdlog) + PROD_W'(|(vco & pmask));
    end
endmodule

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc #(
    parameter int FREQ_W       = 32,
    parameter int WORD_W       = 32,
    parameter int TBL_N        = 5,
    parameter int LOG_W        = 3,
    parameter int DEF_INT_BITS = 7,
    parameter logic [31:0] DEF_VMIN_HZ = 32'd1000000000,
    localparam int SH_W   = $clog2(WORD_W + 1),
    localparam int PROD_W = FREQ_W + WORD_W,
    localparam int NUM_W  = FREQ_W + (2**LOG_W - 1) + WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    rev_mode,
    input  logic [FREQ_W-1:0]       target_hz,
    input  logic [FREQ_W-1:0]       ref_hz,
    input  logic [FREQ_W-1:0]       vco_max_hz,
    input  logic [FREQ_W-1:0]       vco_min_hz,
    input  logic [SH_W-1:0]         word_bits,
    input  logic [SH_W-1:0]         int_bits,
    input  logic                    table_en,
    input  logic [TBL_N*FREQ_W-1:0] table_hz,
    input  logic [WORD_W-1:0]       word_in,
    input  logic [LOG_W-1:0]        pdlog_in,
    output logic [WORD_W-1:0]       word_o,
    output logic [LOG_W-1:0]        pdlog_o,
    output logic [PROD_W-1:0]       rate_o,
    output logic                    valid,
    output logic                    err
);
    import pllc_pkg::*;

    pllc_state_e state_q, state_d;

    logic [FREQ_W-1:0]       tgt_q, ref_q, vmax_q, vmin_q;
    logic [SH_W-1:0]         wb_q, ib_q;
    logic                    rev_q, ten_q;
    logic [TBL_N*FREQ_W-1:0] tbl_q;
    logic [WORD_W-1:0]       win_q, word_q;
    logic [LOG_W-1:0]        plin_q, pdlog_q;
    logic [PROD_W-1:0]       rate_q;

    logic [FREQ_W-1:0] vmin_eff, tgt_eff;
    logic [LOG_W-1:0]  pdlog_sel;
    logic [SH_W-1:0]   ib_eff, wb_eff, frac;
    logic [NUM_W-1:0]  numer;
    logic [WORD_W-1:0] div_quo;
    logic [PROD_W-1:0] rate_calc;
    logic              accept, div_load, div_done;

    // request field defaults and fraction split
    always_comb begin
        vmin_eff = (vmin_q == '0) ? DEF_VMIN_HZ[FREQ_W-1:0] : vmin_q;
        ib_eff   = (ib_q == '0) ? SH_W'(DEF_INT_BITS) : ib_q;
        wb_eff   = (wb_q > SH_W'(WORD_W)) ? SH_W'(WORD_W) : wb_q;
        frac     = (wb_eff > ib_eff) ? (wb_eff - ib_eff) : '0;
        numer    = NUM_W'(tgt_eff) << ({1'b0, frac} + (SH_W+1)'(pdlog_sel));
    end

    pllc_postdiv_sel #(.FREQ_W(FREQ_W), .TBL_N(TBL_N), .LOG_W(LOG_W), .SRCH_N(5)) u_sel (
        .target(tgt_q), .vmax(vmax_q), .vmin_eff(vmin_eff), .tbl_en(ten_q),
        .tbl(tbl_q), .target_eff(tgt_eff), .pdlog(pdlog_sel)
    );

    pllc_restoring_div #(.NUM_W(NUM_W), .DEN_W(FREQ_W), .OUT_W(WORD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_load), .dividend(numer),
        .divisor(ref_q), .quotient(div_quo), .done(div_done)
    );

    pllc_rate_eval #(.FREQ_W(FREQ_W), .WORD_W(WORD_W), .LOG_W(LOG_W), .SH_W(SH_W)) u_rate (
        .ref_hz(ref_q), .word(word_q), .frac(frac), .pdlog(pdlog_q), .rate(rate_calc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: if (start) state_d = ST_PREP;
            ST_PREP: begin
                if (ref_q == '0) state_d = ST_FAULT;
                else if (rev_q)  state_d = ST_RATE;
                else             state_d = ST_DIVIDE;
            end
            ST_DIVIDE: if (div_done) state_d = ST_RATE;
            ST_RATE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        accept   = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAULT);
        div_load = (state_q == ST_PREP) && (ref_q != '0) && !rev_q;
        valid    = (state_q == ST_DONE);
        err      = (state_q == ST_FAULT);
        word_o   = word_q;
        pdlog_o  = pdlog_q;
        rate_o   = rate_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0; ref_q <= '0; vmax_q <= '0; vmin_q <= '0;
            wb_q <= '0; ib_q <= '0; rev_q <= 1'b0; ten_q <= 1'b0;
            tbl_q <= '0; win_q <= '0; plin_q <= '0;
            word_q <= '0; pdlog_q <= '0; rate_q <= '0;
        end else begin
            if (start && accept) begin
                tgt_q <= target_hz; ref_q <= ref_hz;
                vmax_q <= vco_max_hz; vmin_q <= vco_min_hz;
                wb_q <= word_bits; ib_q <= int_bits;
                rev_q <= rev_mode; ten_q <= table_en; tbl_q <= table_hz;
                win_q <= word_in; plin_q <= pdlog_in;
            end
            if (state_q == ST_PREP) begin
                pdlog_q <= rev_q ? plin_q : pdlog_sel;
                if (rev_q) word_q <= win_q;
            end
            if (state_q == ST_DIVIDE && div_done) word_q <= div_quo;
            if (state_q == ST_RATE) rate_q <= rate_calc;
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> (valid && $stable(word_o) && $stable(rate_o) && $stable(pdlog_o))); // R10
    AST_ZERO_REF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREP && ref_q == '0) |=> (err && !valid)); // R9
    AST_PDLOG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !rev_q && !ten_q) |-> (pdlog_o <= LOG_W'(4))); // R2
    AST_REV_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rev_q) |-> (word_o == win_q && pdlog_o == plin_q)); // R8
endmodule

// File: tb/pll_ratio_calc_tb.sv
module pll_ratio_calc_tb;
    typedef struct {
        logic         rev;
        logic [31:0]  tgt, rf, vmax, vmin;
        logic [5:0]   wb, ib;
        logic         ten;
        logic [159:0] tbl;
        logic [31:0]  win;
        logic [2:0]   plin;
    } op_t;

    typedef struct {
        logic        err;
        logic [31:0] word;
        logic [2:0]  pl;
        logic [63:0] rate;
        string       req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic rev_mode = 1'b0, table_en = 1'b0;
    logic [31:0] target_hz = '0, ref_hz = '0, vco_max_hz = '0, vco_min_hz = '0, word_in = '0;
    logic [5:0] word_bits = '0, int_bits = '0;
    logic [159:0] table_hz = '0;
    logic [2:0] pdlog_in = '0;
    logic [31:0] word_o;
    logic [2:0] pdlog_o;
    logic [63:0] rate_o;
    logic valid, err;

    int checks = 0, failures = 0, issued = 0, seen = 0;
    bit finished = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    pll_ratio_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rev_mode(rev_mode),
        .target_hz(target_hz), .ref_hz(ref_hz), .vco_max_hz(vco_max_hz),
        .vco_min_hz(vco_min_hz), .word_bits(word_bits), .int_bits(int_bits),
        .table_en(table_en), .table_hz(table_hz), .word_in(word_in), .pdlog_in(pdlog_in),
        .word_o(word_o), .pdlog_o(pdlog_o), .rate_o(rate_o), .valid(valid), .err(err)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input op_t o, input string req);
        exp_t e;
        logic [127:0] t, num, prod, vco, pd, vmin;
        int k, ibe, wbe, fr;
        e.req = req; e.err = 0; e.word = '0; e.pl = '0; e.rate = '0;
        if (o.rf == 0) begin e.err = 1; return e; end
        ibe = (o.ib == 0) ? 7 : int'(o.ib);
        wbe = (o.wb > 32) ? 32 : int'(o.wb);
        fr  = (wbe > ibe) ? wbe - ibe : 0;
        if (o.rev) begin
            e.word = o.win; k = int'(o.plin);
        end else begin
            t = 128'(o.tgt);
            if (t > 128'(o.vmax)) t = 128'(o.vmax);
            vmin = (o.vmin == 0) ? 128'd1000000000 : 128'(o.vmin);
            if (o.ten) begin
                if (t > 128'(o.tbl[31:0])) t = 128'(o.tbl[31:0]);
                k = 0;
                while (k + 1 < 5 && o.tbl[(k+1)*32 +: 32] != 0 && t <= 128'(o.tbl[(k+1)*32 +: 32])) k++;
            end else begin
                k = 4;
                for (int i = 4; i >= 0; i--) if (t * (128'd1 << i) >= vmin) k = i;
            end
            num = t << (k + fr);
            e.word = 32'(num / 128'(o.rf));
        end
        e.pl = 3'(k);
        prod = 128'(o.rf) * 128'(e.word);
        vco = prod >> fr;
        if (prod % (128'd1 << fr) != 0) vco = vco + 1;
        pd = 128'd1 << k;
        e.rate = 64'((vco + pd - 1) / pd);
        return e;
    endfunction

    function automatic op_t mk(input logic [31:0] tgt, input logic [31:0] rf);
        op_t o;
        o.rev = 0; o.tgt = tgt; o.rf = rf; o.vmax = 32'd3800000000; o.vmin = 0;
        o.wb = 6'd22; o.ib = 0; o.ten = 0; o.tbl = '0; o.win = '0; o.plin = '0;
        return o;
    endfunction

    task automatic drive(input op_t o);
        rev_mode = o.rev; target_hz = o.tgt; ref_hz = o.rf; vco_max_hz = o.vmax;
        vco_min_hz = o.vmin; word_bits = o.wb; int_bits = o.ib; table_en = o.ten;
        table_hz = o.tbl; word_in = o.win; pdlog_in = o.plin;
    endtask

    task automatic issue(input op_t o, input string req);
        drive(o);
        sb.push_back(model(o, req));
        issued++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_all();
        wait (seen == issued);
    endtask

    task automatic run(input op_t o, input string req);
        issue(o, req);
        wait_all();
    endtask

    // monitor / scoreboard
    logic pv = 1'b0, pe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((valid && !pv) || (err && !pe)) begin
                if (sb.size() == 0) begin
                    check("R10", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req, "err", err, e.err);
                    check(e.req, "valid", valid, !e.err);
                    if (!e.err) begin
                        check(e.req, "word", word_o, e.word);
                        check(e.req, "pdlog", pdlog_o, e.pl);
                        check(e.req, "rate", rate_o, e.rate);
                    end
                end
                seen++;
            end
        end
        pv = valid; pe = err;
    end

    initial begin
        int cyc = 0;
        while (cyc < 150000 && !finished) begin @(posedge clk); cyc++; end
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        op_t o, ob;
        logic [31:0] held_w;
        logic [63:0] held_r;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "valid in reset", valid, 0);
        check("R11", "err in reset", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "word after reset", word_o, 0);
        check("R11", "rate after reset", rate_o, 0);
        check("R11", "pdlog after reset", pdlog_o, 0);

        // R5 R3 R4 basic forward, default vmin, default int bits
        run(mk(32'd1500000000, 32'd26000000), "R5");
        // R2 R3 k=2 with default minimum
        run(mk(32'd300000000, 32'd26000000), "R2");
        // R2 no exponent qualifies -> 4
        run(mk(32'd50000000, 32'd26000000), "R2");
        // R3 explicit minimum
        o = mk(32'd300000000, 32'd26000000); o.vmin = 32'd500000000;
        run(o, "R3");
        // R1 clamp to maximum
        o = mk(32'd3000000000, 32'd25000000); o.vmax = 32'd2000000000;
        run(o, "R1");
        // R4 custom split, and word narrower than integer part
        o = mk(32'd1234567890, 32'd27000000); o.wb = 6'd31; o.ib = 6'd8;
        run(o, "R4");
        o = mk(32'd1234567890, 32'd27000000); o.wb = 6'd5;
        run(o, "R4");
        o = mk(32'd1234567890, 32'd27000000); o.wb = 6'd40;
        run(o, "R4");

        // R7 threshold table: 2G,1G,500M,250M,0
        o = mk(32'd3000000000, 32'd26000000); o.ten = 1;
        o.tbl = {32'd0, 32'd250000000, 32'd500000000, 32'd1000000000, 32'd2000000000};
        run(o, "R7");
        o.tgt = 32'd600000000;  run(o, "R7");
        o.tgt = 32'd100000000;  run(o, "R7");

        // R8 R6 reverse with discarded bits set
        o = mk(0, 32'd26000001); o.rev = 1; o.win = 32'h00A5_5A3F; o.plin = 3'd3;
        run(o, "R8");
        o.plin = 3'd7; o.wb = 6'd10; run(o, "R6");

        // R9 zero reference, then recovery
        run(mk(32'd1500000000, 32'd0), "R9");
        issue(mk(32'd800000000, 32'd26000000), "R9");
        check("R9", "err cleared by start", err, 0);
        wait_all();

        // R10 hold
        held_w = word_o; held_r = rate_o;
        repeat (20) @(negedge clk);
        check("R10", "valid held", valid, 1);
        check("R10", "word held", word_o, held_w);
        check("R10", "rate held", rate_o, held_r);

        // R10 start in the same cycle that valid rises
        issue(mk(32'd1000000000, 32'd26000000), "R10");
        wait_all();
        issue(mk(32'd123456789, 32'd19200000), "R10");
        wait_all();

        // R10 start while busy is ignored
        issue(mk(32'd2222222222, 32'd26000000), "R10");
        repeat (10) @(negedge clk);
        ob = mk(32'd77777777, 32'd13000000); ob.rev = 1; ob.win = 32'd5;
        drive(ob);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_all();
        repeat (100) @(negedge clk);
        check("R10", "results count", seen, issued);
        check("R10", "pending items", sb.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule